// File: doc/BRIEF.md
# Background Parity Scrubber

This block holds a small register file in which every word carries one parity bit, either odd or even as chosen at build time. A write stores the data with a freshly computed parity bit. Software reads come out through a registered read port. Each read recomputes the parity of the stored word and compares it with the stored bit. A test input can flip any single stored bit, including the parity bit, so that faults can be planted on purpose.

A background engine also reads the array. It waits a programmable number of idle cycles and then walks every address from zero upward, checking one word on each cycle in which the read port is free. A software read always takes the port. The engine then holds its address and tries it again on the next free cycle. When the last address has been checked, the idle countdown starts over.

A parity mismatch found by either reader raises one shared error flag and captures the failing address on an output. The first failing address is held until software clears the flag.

Top module: `parity_scrubber`

## Requirements
- R1: After reset every word holds zero data with a valid parity bit, `err_flag` is 0, `err_addr` is 0 and `rd_valid` is 0.
- R2: A write stores `wr_data` with a parity bit at position DATA_W. With odd parity (the default) the stored word has an odd number of ones. With even parity it has an even number of ones.
- R3: A software read sampled at a clock edge presents `rd_valid`=1 and the stored data on `rd_data` after that same edge. A write to the same address at that edge is not yet visible to the read.
- R4: An inject flips bit `inj_bit` of the word at `inj_addr`. Index DATA_W selects the parity bit. A write to the same address at the same edge takes precedence over the inject.
- R5: When a software read finds a parity mismatch, `err_flag` is 1 and `err_addr` holds the read address after the same edge that returns the data.
- R6: The background sweep becomes active IDLE_CYCLES edges after reset, or after the edge that checked the last address of the previous sweep. It checks address 0 at the next edge and then one ascending address per free edge.
- R7: Each sweep checks every address from 0 to DEPTH-1, so a fault at the highest address is reported.
- R8: A software read wins the port over the sweep. A blocked sweep keeps its address and checks it on the next free edge, so no address is skipped.
- R9: Once `err_flag` is set, later mismatches do not change `err_addr` until `err_clr` is asserted. A mismatch detected at the same edge as `err_clr` is captured as a new error.
- R10: Faults found by the background sweep are reported on the same `err_flag` and `err_addr` used by software reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Software read request |
| rd_addr | input | ADDR_W | Software read address |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid |
| inj_en | input | 1 | Fault inject strobe |
| inj_addr | input | ADDR_W | Word to corrupt |
| inj_bit | input | IDX_W | Bit index to flip (DATA_W = parity bit) |
| err_clr | input | 1 | Clears the error flag |
| err_flag | output | 1 | Parity error seen |
| err_addr | output | ADDR_W | First failing address |

## Verification
The hardest case to reach from the ports is a sweep that is stalled by software on exactly the address that holds a fault. The sweep's address is never visible, so a skipped or repeated address can only show up in when the error appears. The bench plants a fault, holds a software read on a clean address across the moment the sweep starts, and then releases the port. From that point it counts edges and requires the error to appear exactly when the sweep, resumed at address 0, reaches the faulty word. A second scenario leaves two faults in place and clears the flag between sweeps. The reload interval is then proven by the edge at which the first fault is found again.

// File: rtl/parscrub_pkg.sv
package parscrub_pkg;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } par_kind_e;

    typedef enum logic {
        SQ_WAIT  = 1'b0,
        SQ_SWEEP = 1'b1
    } sweep_state_e;

    // Parity bit that makes the whole stored word match the chosen kind.
    function automatic logic par_bit(input logic [63:0] d, input par_kind_e k);
        return (^d) ^ logic'(k);
    endfunction

    // Mismatch test on a complete word including its parity bit.
    function automatic logic par_bad(input logic [64:0] w, input par_kind_e k);
        return (^w) != logic'(k);
    endfunction

endpackage

// File: rtl/scrub_store.sv
module scrub_store
    import parscrub_pkg::*;
#(
    parameter int        DATA_W = 31,
    parameter int        DEPTH  = 8,
    parameter int        ADDR_W = 3,
    parameter int        IDX_W  = 5,
    parameter par_kind_e KIND   = PAR_ODD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [IDX_W-1:0]  inj_bit,
    input  logic [ADDR_W-1:0] sel_addr,
    output logic [DATA_W:0]   sel_word
);
    localparam int WORD_W = DATA_W + 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic              zero_par;

    assign zero_par = par_bit(64'd0, KIND);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= {zero_par, {DATA_W{1'b0}}};
            end
        end else begin
            if (inj_en && (int'(inj_addr) < DEPTH)) begin
                mem[inj_addr] <= mem[inj_addr] ^ (WORD_W'(1) << inj_bit);
            end
            if (wr_en && (int'(wr_addr) < DEPTH)) begin
                mem[wr_addr] <= {par_bit(64'(wr_data), KIND), wr_data};
            end
        end
    end

    assign sel_word = (int'(sel_addr) < DEPTH) ? mem[sel_addr] : '0;

endmodule

// File: rtl/scrub_sequencer.sv
module scrub_sequencer
    import parscrub_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int ADDR_W      = 3,
    parameter int IDLE_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_req,
    output logic              grant,
    output logic [ADDR_W-1:0] sweep_addr
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0]  CNT_TOP   = CNT_W'(IDLE_CYCLES - 1);

    sweep_state_e     state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_WAIT;
            cnt        <= '0;
            sweep_addr <= '0;
        end else begin
            case (state)
                SQ_WAIT: begin
                    if (cnt == CNT_TOP) begin
                        state      <= SQ_SWEEP;
                        cnt        <= '0;
                        sweep_addr <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (!sw_req) begin
                        if (sweep_addr == LAST_ADDR) begin
                            state <= SQ_WAIT;
                        end else begin
                            sweep_addr <= sweep_addr + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign grant = (state == SQ_SWEEP) && !sw_req;

    // R8
    sniff_yield_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_SWEEP && sw_req) |=> (state == SQ_SWEEP && $stable(sweep_addr)));

    // R7
    sweep_end_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_WAIT && $past(state) == SQ_SWEEP) |-> $past(sweep_addr) == LAST_ADDR);

    // R6
    idle_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_WAIT) |-> (int'(cnt) < IDLE_CYCLES));

endmodule

// File: rtl/scrub_errlog.sv
module scrub_errlog #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [ADDR_W-1:0] hit_addr,
    input  logic              clr,
    output logic              err_flag,
    output logic [ADDR_W-1:0] err_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag <= 1'b0;
            err_addr <= '0;
        end else if (hit && (!err_flag || clr)) begin
            err_flag <= 1'b1;
            err_addr <= hit_addr;
        end else if (clr) begin
            err_flag <= 1'b0;
        end
    end

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clr) |=> (err_flag && $stable(err_addr)));

endmodule

// File: rtl/parity_scrubber.sv
module parity_scrubber
    import parscrub_pkg::*;
#(
    parameter int        DATA_W      = 31,
    parameter int        DEPTH       = 8,
    parameter int        IDLE_CYCLES = 20,
    parameter par_kind_e KIND        = PAR_ODD,
    localparam int       ADDR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int       IDX_W       = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [IDX_W-1:0]  inj_bit,
    input  logic              err_clr,
    output logic              err_flag,
    output logic [ADDR_W-1:0] err_addr
);
    logic              grant;
    logic [ADDR_W-1:0] sweep_addr;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W:0]   sel_word;
    logic              chk_bad;
    logic              hit;

    assign sel_addr = rd_en ? rd_addr : sweep_addr;

    scrub_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .KIND   (KIND)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .inj_en   (inj_en),
        .inj_addr (inj_addr),
        .inj_bit  (inj_bit),
        .sel_addr (sel_addr),
        .sel_word (sel_word)
    );

    scrub_sequencer #(
        .DEPTH       (DEPTH),
        .ADDR_W      (ADDR_W),
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .sw_req     (rd_en),
        .grant      (grant),
        .sweep_addr (sweep_addr)
    );

    assign chk_bad = par_bad(65'(sel_word), KIND);
    assign hit     = (rd_en || grant) && chk_bad;

    scrub_errlog #(
        .ADDR_W (ADDR_W)
    ) u_err (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .hit_addr (sel_addr),
        .clr      (err_clr),
        .err_flag (err_flag),
        .err_addr (err_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= sel_word[DATA_W-1:0];
            end
        end
    end

    // R3
    rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R5
    err_from_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && chk_bad) |=> err_flag);

endmodule

// File: tb/tb_parity_scrubber.sv
module tb_parity_scrubber;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 31;
    localparam int DEP  = 8;
    localparam int IDLE = 20;
    localparam int AW   = 3;
    localparam int IW   = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en, rd_en, inj_en, err_clr;
    logic [AW-1:0] wr_addr, rd_addr, inj_addr;
    logic [DW-1:0] wr_data;
    logic [IW-1:0] inj_bit;
    logic [DW-1:0] rd_data;
    logic          rd_valid, err_flag;
    logic [AW-1:0] err_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    parity_scrubber dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit),
        .err_clr(err_clr), .err_flag(err_flag), .err_addr(err_addr)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        wr_en = 0; rd_en = 0; inj_en = 0; err_clr = 0;
        wr_addr = '0; rd_addr = '0; inj_addr = '0; wr_data = '0; inj_bit = '0;
    endtask

    // One edge: inputs already driven at a falling edge, sample at the next falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        quiet();
        rst = 1;
        tick();
        tick();
        rst = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(err_flag == 0, "R1 err_flag", err_flag, 0);
        check(err_addr == 0, "R1 err_addr", err_addr, 0);
        check(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
        rd_en = 1; rd_addr = 6; tick(); quiet();
        check(rd_data == 0 && err_flag == 0, "R1 cleared word clean", {rd_data, err_flag}, 0);
    endtask

    task automatic t_write_read();
        logic [DW-1:0] vals [4] = '{31'h0, 31'h7fff_ffff, 31'h1234_5678, 31'h0000_0001};
        do_reset();
        for (int i = 0; i < 4; i++) begin
            wr_en = 1; wr_addr = AW'(i + 2); wr_data = vals[i]; tick(); quiet();
        end
        for (int i = 0; i < 4; i++) begin
            rd_en = 1; rd_addr = AW'(i + 2); tick(); quiet();
            check(rd_valid == 1, "R3 rd_valid", rd_valid, 1);
            check(rd_data == vals[i], "R2 read back", rd_data, vals[i]);
            check(err_flag == 0, "R2 parity stored", err_flag, 0);
        end
        // same-edge write and read: old contents returned
        rd_en = 1; rd_addr = 3; wr_en = 1; wr_addr = 3; wr_data = 31'h55; tick(); quiet();
        check(rd_data == vals[1], "R3 read before write", rd_data, vals[1]);
        rd_en = 1; rd_addr = 3; tick(); quiet();
        check(rd_data == 31'h55, "R3 write then visible", rd_data, 31'h55);
    endtask

    task automatic t_sw_errors();
        do_reset();
        inj_en = 1; inj_addr = 5; inj_bit = 0; tick(); quiet();
        rd_en = 1; rd_addr = 5; tick(); quiet();
        check(rd_data == 1, "R4 data bit flipped", rd_data, 1);
        check(err_flag == 1, "R5 flag on read", err_flag, 1);
        check(err_addr == 5, "R5 address on read", err_addr, 5);
        err_clr = 1; tick(); quiet();
        check(err_flag == 0, "R9 clear", err_flag, 0);
        // flip the parity bit itself
        inj_en = 1; inj_addr = 4; inj_bit = IW'(DW); tick(); quiet();
        rd_en = 1; rd_addr = 4; tick(); quiet();
        check(err_flag == 1 && err_addr == 4, "R4 parity bit flip", err_addr, 4);
        check(rd_data == 0, "R4 data untouched", rd_data, 0);
        err_clr = 1; tick(); quiet();
        // write wins over inject at same edge
        wr_en = 1; wr_addr = 3; wr_data = 31'h0abc; inj_en = 1; inj_addr = 3; inj_bit = 2;
        tick(); quiet();
        rd_en = 1; rd_addr = 3; tick(); quiet();
        check(rd_data == 31'h0abc && err_flag == 0, "R4 write precedence", rd_data, 31'h0abc);
    endtask

    // Fault planted at edge 1; sweep reports it at edge IDLE+1+addr.
    task automatic t_sweep_detect(input int a);
        int first = -1;
        do_reset();
        for (int n = 1; n <= 40; n++) begin
            if (n == 1) begin inj_en = 1; inj_addr = AW'(a); inj_bit = 7; end
            tick(); quiet();
            if (err_flag && first < 0) first = n;
        end
        check(first == IDLE + 1 + a, "R6 R7 R10 sweep detect edge", first, IDLE + 1 + a);
        check(err_addr == AW'(a), "R10 sweep address", err_addr, a);
    endtask

    task automatic t_yield();
        int first = -1;
        bit rd_ok = 1;
        do_reset();
        for (int n = 1; n <= 60; n++) begin
            if (n == 1) begin inj_en = 1; inj_addr = 2; inj_bit = 3; end
            if (n <= 40) begin rd_en = 1; rd_addr = 0; end
            tick(); quiet();
            if (n <= 40 && !(rd_valid && rd_data == 0)) rd_ok = 0;
            if (err_flag && first < 0) first = n;
        end
        check(rd_ok, "R8 software read served", rd_ok, 1);
        check(first == 43, "R8 sweep resumes without skip", first, 43);
        check(err_addr == 2, "R8 address", err_addr, 2);
    endtask

    task automatic t_hold_and_reload();
        int first = -1, second = -1;
        do_reset();
        for (int n = 1; n <= 60; n++) begin
            if (n == 1) begin inj_en = 1; inj_addr = 1; inj_bit = 9; end
            if (n == 2) begin inj_en = 1; inj_addr = 6; inj_bit = 9; end
            if (n == 35) err_clr = 1;
            tick(); quiet();
            if (err_flag && first < 0) first = n;
            if (n == 30) check(err_addr == 1, "R9 first address held", err_addr, 1);
            if (n == 40) check(err_flag == 0, "R9 flag cleared", err_flag, 0);
            if (n > 35 && err_flag && second < 0) second = n;
        end
        check(first == 22, "R6 first sweep", first, 22);
        check(second == 50, "R6 interval reload", second, 50);
        check(err_addr == 1, "R9 recapture", err_addr, 1);
    endtask

    task automatic t_clear_and_hit();
        do_reset();
        inj_en = 1; inj_addr = 2; inj_bit = 1; tick(); quiet();
        inj_en = 1; inj_addr = 7; inj_bit = 1; tick(); quiet();
        rd_en = 1; rd_addr = 2; tick(); quiet();
        rd_en = 1; rd_addr = 7; err_clr = 1; tick(); quiet();
        check(err_flag == 1 && err_addr == 7, "R9 hit during clear", err_addr, 7);
    endtask

    initial begin
        rst = 1;
        quiet();
        t_reset_state();
        t_write_read();
        t_sw_errors();
        t_sweep_detect(3);
        t_sweep_detect(DEP - 1);
        t_yield();
        t_hold_and_reload();
        t_clear_and_hit();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule